// File: doc/BRIEF.md
# Group-Ring DMA Sequencer

This block is the control and progress core of a two-direction DMA engine that moves data in groups of fixed-size blocks. Software sets up each direction through a 32-bit register port. It writes the block size in bytes, the number of blocks per group, the number of groups in the ring and how many groups should finish before an interrupt. It also loads a start address for every group into a table. The table is reached through a 32-slot window per direction, and one page-select register shared by both directions chooses which bank of 32 groups the window shows.

While the global run bit is set, the block gives each direction's external bus master the next block address. That address is the current group's start address plus the block index times the block size. Each completed block arrives as a one-cycle pulse on that direction's done input. When the last block of a group completes, the current-group index moves forward and wraps to zero after the last group. Software can read this index and work out how many groups are new by subtracting, modulo the group count. After the programmed number of groups, a per-direction status bit sets and the interrupt output asserts if that bit is unmasked. Reading the status register clears it.

Top module: `sgd_top`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: every register, every table slot, both current-group indices, both block indices, the status bits, `irq`, `mst_req` and `mst_addr`.
- R2: Register byte offsets are: run bit 0x000 (bit 0); page select 0x004 (8 bits); status 0x008; interrupt mask 0x00C; receive block bytes 0x010, blocks per group 0x014, group count 0x018, groups per interrupt 0x01C; transmit equivalents at 0x020, 0x024, 0x028 and 0x02C; current group, read-only, at 0x030 for receive and 0x034 for transmit. Configuration registers read back what was written. Group-count and groups-per-interrupt writes above MAX_GROUPS are stored as MAX_GROUPS.
- R3: Group g's start address sits in window slot g mod 32 while the page register holds g/32. The receive window covers bytes 0x040–0x0BC and the transmit window 0x0C0–0x13C, one 32-bit slot every 4 bytes. Slots read back through the same window. For groups at or beyond MAX_GROUPS, writes are ignored and reads return 0.
- R4: `mst_req[d]` is high exactly when the run bit is set and both the group count and blocks per group of direction d are non-zero. `mst_addr[d]` equals the current group's start address plus the block index times the block size. `mst_len[d]` equals the block size.
- R5: A done pulse on an active direction advances its block index. The pulse that completes the last block of a group resets the block index to 0 and advances the current group, which wraps to 0 after group count − 1.
- R6: When the run bit is 0, done pulses are ignored. Indices and addresses do not change.
- R7: When the number of groups completed since the last interrupt event reaches groups-per-interrupt, the direction's status bit sets: bit 0 for receive, bit 1 for transmit. A programmed value of 0 behaves as 1.
- R8: A read of the status register clears the bits that were read. A new event in the same cycle still sets its bit. `irq` is high when any status bit is set and its mask bit (same positions) is set.
- R9: Writing any of a direction's four configuration registers restarts that direction's block index, current group and groups-completed count at 0.
- R10: The two directions count independently. Done pulses on one direction never move the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when reading the status register) |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| blk_done | input | 2 | One-cycle block-completion pulse; bit 0 receive, bit 1 transmit |
| mst_req | output | 2 | Direction has a block to move |
| mst_addr | output | 64 | Next block address; bits 31:0 receive, 63:32 transmit |
| mst_len | output | 64 | Block length in bytes, same packing |
| irq | output | 1 | DMA interrupt |

## Verification
The bench goes after several corner cases:
- The ring wrap from the last group back to 0. A design with an off-by-one compare would show group count or skip a group.
- A second-page group, reached with page 1. A design that ignored the page would alias it onto group 1's address.
- An interrupt window that spans a wrap, and a groups-per-interrupt of 0. The first stalls or floods a wrong design; the second would never interrupt.
- A masked status bit. It must stay readable while `irq` stays low.
- A status read, which must clear the bit.
- Done pulses while stopped, and done pulses on the other direction. Both must leave the indices and addresses unchanged.
- An out-of-range page write. A design that truncated the index would overwrite a low group's slot.

// File: rtl/sgd_pkg.sv
// Package: shared register offsets and field selectors for the group DMA
// sequencer. Assumes a 9-bit byte address space, 32-bit registers.
package sgd_pkg;
    localparam int REG_AW  = 9;
    localparam int REG_DW  = 32;
    localparam int NDIR    = 2;
    localparam int SLOTS   = 32;
    localparam int PAGE_W  = 8;

    localparam logic [REG_AW-1:0] A_RUN  = 9'h000;
    localparam logic [REG_AW-1:0] A_PAGE = 9'h004;
    localparam logic [REG_AW-1:0] A_STAT = 9'h008;
    localparam logic [REG_AW-1:0] A_MASK = 9'h00C;

    typedef enum logic [1:0] {
        F_BYTES = 2'd0,
        F_BPG   = 2'd1,
        F_GCNT  = 2'd2,
        F_GPI   = 2'd3
    } chan_field_e;

    // Base byte offset of a direction's four configuration registers.
    function automatic logic [REG_AW-1:0] cfg_base(input int d);
        return REG_AW'(9'h010 + 9'h010 * d);
    endfunction

    // Byte offset of a direction's read-only current-group register.
    function automatic logic [REG_AW-1:0] cur_addr(input int d);
        return REG_AW'(9'h030 + 9'h004 * d);
    endfunction

    // Byte offset of a direction's first address-table window slot.
    function automatic logic [REG_AW-1:0] win_base(input int d);
        return REG_AW'(9'h040 + 9'h080 * d);
    endfunction
endpackage

// File: rtl/sgd_addr_table.sv
// Group start-address table for one direction. One synchronous write port
// and two combinational read ports: one for software readback, one for the
// current group. The caller range-checks indices; reset clears all entries.
module sgd_addr_table #(
    parameter int MAX_GROUPS = 64,
    localparam int IDX_W = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    input  logic [IDX_W-1:0] cur_idx,
    output logic [31:0]      cur_base
);
    logic [31:0] mem [MAX_GROUPS];

    // Store a slot on write; clear the table on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_GROUPS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data  = mem[rd_idx];
    assign cur_base = mem[cur_idx];
endmodule

// File: rtl/sgd_chan_ctr.sv
// Block and group progress counter for one direction. Counts done pulses
// into blocks, blocks into groups, and wraps the group index over the ring.
// Emits a one-cycle event every groups-per-interrupt groups (0 acts as 1).
// Assumes bpg and gcnt are stable except when restart is pulsed.
module sgd_chan_ctr #(
    parameter int BLK_W = 16,
    parameter int GRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [BLK_W-1:0] bpg,
    input  logic [GRP_W:0]   gcnt,
    input  logic [GRP_W:0]   gpi,
    input  logic             blk_done,
    output logic             active,
    output logic [BLK_W-1:0] blk_idx,
    output logic [GRP_W-1:0] grp_idx,
    output logic             grp_evt
);
    logic [GRP_W:0] done_ctr;
    logic [GRP_W:0] gpi_eff;
    logic           last_blk;
    logic           last_grp;
    logic           grp_step;

    // Qualify the channel and decode end-of-group and interrupt conditions.
    always_comb begin
        active   = run && (gcnt != '0) && (bpg != '0);
        gpi_eff  = (gpi == '0) ? (GRP_W+1)'(1) : gpi;
        last_blk = (blk_idx == bpg - 1'b1);
        last_grp = ({1'b0, grp_idx} == gcnt - 1'b1);
        grp_step = active && blk_done && last_blk;
        grp_evt  = grp_step && ((done_ctr + 1'b1) >= gpi_eff);
    end

    // Advance block, group and groups-completed counters.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            blk_idx  <= '0;
            grp_idx  <= '0;
            done_ctr <= '0;
        end else if (active && blk_done) begin
            if (last_blk) begin
                blk_idx  <= '0;
                grp_idx  <= last_grp ? '0 : grp_idx + 1'b1;
                done_ctr <= grp_evt ? '0 : done_ctr + 1'b1;
            end else begin
                blk_idx <= blk_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sgd_top.sv
// Group-ring DMA sequencer top: register file, shared page-select window
// onto two address tables, per-direction progress counters and interrupt
// status/mask. Assumes single-cycle register strobes and combinational read.
module sgd_top #(
    parameter int MAX_GROUPS = 64,
    parameter int BLK_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [8:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [1:0]  blk_done,
    output logic [1:0]  mst_req,
    output logic [63:0] mst_addr,
    output logic [63:0] mst_len,
    output logic        irq
);
    import sgd_pkg::*;

    localparam int GRP_W = (MAX_GROUPS > 1) ? $clog2(MAX_GROUPS) : 1;
    localparam int FULL_W = PAGE_W + 5;
    localparam logic [GRP_W:0] GMAX = (GRP_W+1)'(MAX_GROUPS);

    logic               run_q;
    logic [PAGE_W-1:0]  page_q;
    logic [NDIR-1:0]    stat_q;
    logic [NDIR-1:0]    mask_q;
    logic [NDIR-1:0]    grp_evt;
    logic [NDIR-1:0]    cfg_wr;
    logic               stat_rd;
    logic [NDIR*GRP_W-1:0] grp_idx_all;
    logic [NDIR*BLK_W-1:0] blk_idx_all;
    logic [NDIR*(GRP_W+1)-1:0] gcnt_all;
    logic [NDIR*32-1:0] chan_rdata;
    logic [NDIR-1:0]    chan_hit;

    assign stat_rd = reg_rd && (reg_addr == A_STAT);

    // Clamp a written count to the table size.
    function automatic logic [GRP_W:0] clamp_cnt(input logic [31:0] v);
        return (v > 32'(MAX_GROUPS)) ? GMAX : v[GRP_W:0];
    endfunction

    // Global registers: run bit, page select, mask, interrupt status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            page_q <= '0;
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (reg_wr && reg_addr == A_RUN)  run_q  <= reg_wdata[0];
            if (reg_wr && reg_addr == A_PAGE) page_q <= reg_wdata[PAGE_W-1:0];
            if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[NDIR-1:0];
            stat_q <= (stat_rd ? '0 : stat_q) | grp_evt;
        end
    end

    assign irq = |(stat_q & mask_q);

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        logic [31:0]      bytes_q;
        logic [BLK_W-1:0] bpg_q;
        logic [GRP_W:0]   gcnt_q;
        logic [GRP_W:0]   gpi_q;
        logic [BLK_W-1:0] blk_idx;
        logic [GRP_W-1:0] grp_idx;
        logic [31:0]      cur_base;
        logic [31:0]      tbl_rd;
        logic [8:0]       win_off;
        logic             win_hit;
        logic [FULL_W-1:0] full_idx;
        logic             in_range;
        logic             cfg_hit;
        logic [1:0]       fsel;
        logic             active;

        // Decode this direction's configuration block and table window.
        always_comb begin
            cfg_hit  = (reg_addr >= cfg_base(d)) && (reg_addr < cfg_base(d) + 9'h010);
            fsel     = reg_addr[3:2];
            win_off  = reg_addr - win_base(d);
            win_hit  = (reg_addr >= win_base(d)) && ({1'b0, reg_addr} < {1'b0, win_base(d)} + 10'h080);
            full_idx = {page_q, win_off[6:2]};
            in_range = full_idx < FULL_W'(MAX_GROUPS);
        end

        assign cfg_wr[d] = reg_wr && cfg_hit;

        // Configuration registers of one direction.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q <= '0;
                bpg_q   <= '0;
                gcnt_q  <= '0;
                gpi_q   <= '0;
            end else if (cfg_wr[d]) begin
                case (chan_field_e'(fsel))
                    F_BYTES: bytes_q <= reg_wdata;
                    F_BPG:   bpg_q   <= reg_wdata[BLK_W-1:0];
                    F_GCNT:  gcnt_q  <= clamp_cnt(reg_wdata);
                    default: gpi_q   <= clamp_cnt(reg_wdata);
                endcase
            end
        end

        sgd_addr_table #(.MAX_GROUPS(MAX_GROUPS)) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr && win_hit && in_range),
            .wr_idx   (full_idx[GRP_W-1:0]),
            .wr_data  (reg_wdata),
            .rd_idx   (full_idx[GRP_W-1:0]),
            .rd_data  (tbl_rd),
            .cur_idx  (grp_idx),
            .cur_base (cur_base)
        );

        sgd_chan_ctr #(.BLK_W(BLK_W), .GRP_W(GRP_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q),
            .restart  (cfg_wr[d]),
            .bpg      (bpg_q),
            .gcnt     (gcnt_q),
            .gpi      (gpi_q),
            .blk_done (blk_done[d]),
            .active   (active),
            .blk_idx  (blk_idx),
            .grp_idx  (grp_idx),
            .grp_evt  (grp_evt[d])
        );

        // Per-direction readback selection.
        always_comb begin
            chan_hit[d] = 1'b1;
            chan_rdata[d*32 +: 32] = '0;
            if (win_hit)
                chan_rdata[d*32 +: 32] = in_range ? tbl_rd : '0;
            else if (reg_addr == cur_addr(d))
                chan_rdata[d*32 +: 32] = 32'(grp_idx);
            else if (cfg_hit) begin
                case (chan_field_e'(fsel))
                    F_BYTES: chan_rdata[d*32 +: 32] = bytes_q;
                    F_BPG:   chan_rdata[d*32 +: 32] = 32'(bpg_q);
                    F_GCNT:  chan_rdata[d*32 +: 32] = 32'(gcnt_q);
                    default: chan_rdata[d*32 +: 32] = 32'(gpi_q);
                endcase
            end else
                chan_hit[d] = 1'b0;
        end

        assign mst_req[d]            = active;
        assign mst_addr[d*32 +: 32]  = cur_base + ({{(32-BLK_W){1'b0}}, blk_idx} * bytes_q);
        assign mst_len[d*32 +: 32]   = bytes_q;
        assign grp_idx_all[d*GRP_W +: GRP_W] = grp_idx;
        assign blk_idx_all[d*BLK_W +: BLK_W] = blk_idx;
        assign gcnt_all[d*(GRP_W+1) +: GRP_W+1] = gcnt_q;
    end

    // Top-level read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (chan_hit[0])             reg_rdata = chan_rdata[31:0];
        else if (chan_hit[1])        reg_rdata = chan_rdata[63:32];
        else if (reg_addr == A_RUN)  reg_rdata = {31'd0, run_q};
        else if (reg_addr == A_PAGE) reg_rdata = 32'(page_q);
        else if (reg_addr == A_STAT) reg_rdata = 32'(stat_q);
        else if (reg_addr == A_MASK) reg_rdata = 32'(mask_q);
    end
endmodule

// File: rtl/sgd_checker.sv
// Checker for sgd_top: ring bounds, stop behaviour and interrupt status
// causality/clearing, per direction. Attached by bind below.
module sgd_checker #(
    parameter int GRP_W = 6,
    parameter int BLK_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run,
    input logic                   stat_rd,
    input logic [1:0]             cfg_wr,
    input logic [1:0]             blk_done,
    input logic [1:0]             evt,
    input logic [1:0]             stat,
    input logic [2*GRP_W-1:0]     grp_idx,
    input logic [2*BLK_W-1:0]     blk_idx,
    input logic [2*(GRP_W+1)-1:0] gcnt
);
    for (genvar d = 0; d < 2; d++) begin : g_chk
        // R5: current group stays inside the ring.
        p_idx_in_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (gcnt[d*(GRP_W+1) +: GRP_W+1] != '0)
            |-> ({1'b0, grp_idx[d*GRP_W +: GRP_W]} < gcnt[d*(GRP_W+1) +: GRP_W+1]));
        // R6: no progress while stopped.
        p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !cfg_wr[d])
            |=> ($stable(grp_idx[d*GRP_W +: GRP_W]) && $stable(blk_idx[d*BLK_W +: BLK_W])));
        // R8: a status read with no new event clears the bit.
        p_stat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_rd && !evt[d]) |=> !stat[d]);
        // R7: a status bit only rises after a block completion on its direction.
        p_stat_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat[d]) |-> $past(blk_done[d]));
    end
endmodule

bind sgd_top sgd_checker #(.GRP_W(GRP_W), .BLK_W(BLK_W)) u_sgd_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .stat_rd  (stat_rd),
    .cfg_wr   (cfg_wr),
    .blk_done (blk_done),
    .evt      (grp_evt),
    .stat     (stat_q),
    .grp_idx  (grp_idx_all),
    .blk_idx  (blk_idx_all),
    .gcnt     (gcnt_all)
);

// File: tb/test_sgd_top.sv
module test_sgd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  blk_done = '0;
    logic [1:0]  mst_req;
    logic [63:0] mst_addr;
    logic [63:0] mst_len;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sgd_top i_sgd_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .blk_done(blk_done), .mst_req(mst_req), .mst_addr(mst_addr),
        .mst_len(mst_len), .irq(irq)
    );

    // Vector: {dir, pulses, exp_group, exp_addr, exp_status}
    localparam int NV = 10;
    localparam logic [50:0] VEC [NV] = '{
        {1'b0, 8'd1,  8'd0,  32'h0000_1100, 2'b00},
        {1'b0, 8'd3,  8'd1,  32'h0000_2000, 2'b00},
        {1'b0, 8'd6,  8'd2,  32'h0000_3200, 2'b01},
        {1'b0, 8'd2,  8'd0,  32'h0000_1000, 2'b00},
        {1'b0, 8'd4,  8'd1,  32'h0000_2000, 2'b01},
        {1'b1, 8'd1,  8'd0,  32'h0000_8040, 2'b00},
        {1'b1, 8'd1,  8'd1,  32'h0000_8800, 2'b10},
        {1'b1, 8'd64, 8'd33, 32'h0000_9000, 2'b10},
        {1'b1, 8'd3,  8'd34, 32'h0000_9840, 2'b10},
        {1'b1, 8'd1,  8'd0,  32'h0000_8000, 2'b10}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input int dir, input int n);
        if (n > 0) begin
            @(negedge clk);
            blk_done[dir] = 1'b1;
            repeat (n) @(negedge clk);
            blk_done[dir] = 1'b0;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        #1;
        chk("R1 irq", irq, 0);
        chk("R1 mst_req", mst_req, 0);
        chk("R1 mst_addr", mst_addr, 0);
        rd(9'h008, r); chk("R1 status", r, 0);
        rd(9'h030, r); chk("R1 rx group", r, 0);
        rd(9'h0C0, r); chk("R1 tx slot0", r, 0);

        // Configure receive: 0x100-byte blocks, 4 per group, 3 groups, irq every 2
        wr(9'h010, 32'h100); wr(9'h014, 4); wr(9'h018, 3); wr(9'h01C, 2);
        // Transmit: 0x40-byte blocks, 2 per group, 35 groups, irq every group
        wr(9'h020, 32'h40); wr(9'h024, 2); wr(9'h028, 35); wr(9'h02C, 1);
        wr(9'h004, 0);
        wr(9'h040, 32'h1000); wr(9'h044, 32'h2000); wr(9'h048, 32'h3000);
        wr(9'h0C0, 32'h8000); wr(9'h0C4, 32'h8800);
        wr(9'h004, 1);
        wr(9'h0C4, 32'h9000); wr(9'h0C8, 32'h9800);
        wr(9'h00C, 3);
        @(negedge clk); #1;
        chk("R4 req before run", mst_req, 2'b00);
        wr(9'h000, 1);
        #1;
        chk("R4 req with run", mst_req, 2'b11);
        chk("R4 rx len", mst_len[31:0], 32'h100);
        chk("R4 tx len", mst_len[63:32], 32'h40);
        chk("R4 rx first addr", mst_addr[31:0], 32'h1000);

        // R5/R7/R4 vector table
        for (int v = 0; v < NV; v++) begin
            logic        dir;
            logic [7:0]  np;
            logic [7:0]  eg;
            logic [31:0] ea;
            logic [1:0]  es;
            {dir, np, eg, ea, es} = VEC[v];
            pulse(int'(dir), int'(np));
            #1;
            chk($sformatf("R4 vec%0d addr", v), dir ? mst_addr[63:32] : mst_addr[31:0], ea);
            chk($sformatf("R8 vec%0d irq", v), irq, es != 0);
            rd(dir ? 9'h034 : 9'h030, r);
            chk($sformatf("R5 vec%0d group", v), r, eg);
            rd(9'h008, r);
            chk($sformatf("R7 vec%0d status", v), r, es);
        end
        rd(9'h008, r); chk("R8 status cleared by read", r, 0);

        // R10: receive untouched by transmit activity
        #1 chk("R10 rx addr after tx", mst_addr[31:0], 32'h2000);

        // R3 paged readback and out-of-range page
        wr(9'h004, 1);
        rd(9'h0C4, r); chk("R3 tx group33 readback", r, 32'h9000);
        wr(9'h004, 0);
        rd(9'h0C4, r); chk("R3 tx group1 readback", r, 32'h8800);
        wr(9'h004, 2);
        wr(9'h040, 32'hDEAD);
        rd(9'h040, r); chk("R3 out of range reads 0", r, 0);
        wr(9'h004, 0);
        rd(9'h040, r); chk("R3 group0 not aliased", r, 32'h1000);

        // R6 stopped: done pulses ignored
        wr(9'h000, 0);
        pulse(0, 5);
        #1;
        chk("R6 rx addr held", mst_addr[31:0], 32'h2000);
        chk("R6 req low", mst_req, 2'b00);
        rd(9'h030, r); chk("R6 rx group held", r, 1);
        wr(9'h000, 1);

        // R8 mask: tx event with only rx unmasked
        wr(9'h00C, 1);
        pulse(1, 2);
        #1 chk("R8 masked irq low", irq, 0);
        rd(9'h008, r); chk("R8 masked status visible", r, 2'b10);

        // R9 restart on config write; R7 gpi of 0 acts as 1
        wr(9'h01C, 0);
        #1 chk("R9 rx addr restarted", mst_addr[31:0], 32'h1000);
        rd(9'h030, r); chk("R9 rx group restarted", r, 0);
        pulse(0, 4);
        #1 chk("R7 gpi0 irq", irq, 1);
        rd(9'h008, r); chk("R7 gpi0 status", r, 2'b01);

        // R2 readback and clamp
        rd(9'h010, r); chk("R2 rx bytes readback", r, 32'h100);
        wr(9'h028, 100);
        rd(9'h028, r); chk("R2 tx group count clamp", r, 64);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule